// File: doc/BRIEF.md
# Burst-Paced Bitmap Line Fetcher

This block sits in the bus clock domain and keeps a two-line video cache filled from main memory. The video timing side asks for data by flipping a single toggle line. The block synchronizes that toggle and answers each request with one fixed 32-byte burst read on a simple memory port. Each returned byte is written into the bus-side port of a dual-port line RAM. The video clock reads the other port of that RAM, outside this block.

A display row holds 416 bytes, so it is built from 13 bursts spaced out by the video-side request rate. This lets other memory masters use the memory in the gaps between bursts. Rows alternate between two 512-byte halves of the line RAM. The burst address is formed from one of two frame base addresses, the row number and the burst position. The base is picked by a page-select input, and that input is taken only when the first burst of a frame is accepted, so software can flip pages without tearing a frame.

Top module: `burst_line_fetcher`

## Requirements
- R1: Each accepted request produces exactly one burst. `mem_req` is held high until `mem_ack` is seen, and falls in the cycle after it. Then exactly 32 line RAM writes follow, one per `mem_dvalid` beat.
- R2: The burst address is the page base plus row × 416 plus burst index × 32, where the burst index runs from 0 to 12 within a row.
- R3: The line RAM write address is (row bit 0) × 512 + burst index × 32 + beat, where beat counts the data-valid beats of the burst from 0 to 31. The write data equals `mem_rdata` in the same cycle.
- R4: After the 13th burst of a row, the next burst starts the following row at burst index 0. After the last row of the frame (`FRAME_ROWS`, 262 by default), the row number returns to 0.
- R5: `page_sel` is sampled only when the burst at row 0, burst index 0 is accepted. A value of 0 selects `PAGE0_BASE` and 1 selects `PAGE1_BASE`. A change at any other time has no effect on addresses until the next frame starts.
- R6: Each change of level on `vid_req_tgl` is one request. It passes through a two-flop synchronizer, and `mem_req` rises after the fourth rising clock edge that follows the toggle, provided the fetcher is idle.
- R7: A request that arrives while a burst is in progress is held. Its burst starts once the current burst has finished, with no further toggle.
- R8: While reset is active, `mem_req` and `lram_we` are low, and the first burst after reset fetches row 0, burst index 0.
- R9: A `mem_dvalid` pulse outside the data phase of a burst produces no line RAM write and does not shift the beat count of later bursts.
- R10: `mem_addr` stays stable while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vid_req_tgl | input | 1 | Fetch request toggle from the video clock domain |
| page_sel | input | 1 | Frame page choice, taken at frame start |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | ADDR_W | Byte address of the burst |
| mem_ack | input | 1 | Memory has accepted the request |
| mem_dvalid | input | 1 | A read data byte is valid |
| mem_rdata | input | 8 | Read data byte |
| lram_we | output | 1 | Line RAM write enable |
| lram_waddr | output | LRAM_AW | Line RAM write address |
| lram_wdata | output | 8 | Line RAM write data |

## Verification
A toggle on the request line shows up as `mem_req` after the fourth rising edge: two synchronizer stages, the edge detector feeding the pending flag, and the state register. The bench counts those edges once and samples just after each of them. Line RAM writes are combinational on the data-valid beat, so each write is due in the same cycle as its beat. A reference model compares every write in the middle of the low clock phase, after the memory model has driven its inputs and before the next edge. The memory model checks burst addresses when it first sees `mem_req`, from its own row, burst and page counters. Held requests and stray beats are judged by burst counts and write counts at quiet points.

// File: rtl/lfetch_pkg.sv
// Shared types for the burst line fetcher.
// Assumes: nothing beyond standard SystemVerilog packages.
package lfetch_pkg;
    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_ADDR = 2'd1,
        FS_DATA = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/lfetch_req_sync.sv
// Brings the request toggle from the video domain into the bus clock and
// turns each level change into a one-cycle pulse.
// Assumes: the toggle changes no more often than once every few bus cycles.
module lfetch_req_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl_in,
    output logic req_pulse
);
    logic meta_q, sync_q, last_q;

    // Two synchronizer flops, then one flop to detect a level change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= tgl_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign req_pulse = sync_q ^ last_q;
endmodule

// File: rtl/lfetch_seq.sv
// Burst sequencer: holds one pending request, raises the memory request
// until it is acknowledged, then counts the data-valid beats of the burst.
// Assumes: memory returns exactly BURST_BYTES beats after each acknowledge.
module lfetch_seq #(
    parameter int BURST_BYTES = 32,
    localparam int BEAT_W = $clog2(BURST_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_pulse,
    input  logic              mem_ack,
    input  logic              mem_dvalid,
    output logic              mem_req,
    output logic              accept,
    output logic              burst_done,
    output logic              beat_we,
    output logic [BEAT_W-1:0] beat
);
    import lfetch_pkg::*;

    fetch_state_t state_q;
    logic         pend_q;
    logic         last_beat;

    assign accept     = (state_q == FS_IDLE) && pend_q;
    assign mem_req    = (state_q == FS_ADDR);
    assign beat_we    = (state_q == FS_DATA) && mem_dvalid;
    assign last_beat  = (beat == BEAT_W'(BURST_BYTES - 1));
    assign burst_done = beat_we && last_beat;

    // Pending flag: a new pulse wins over the clear on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (req_pulse) begin
            pend_q <= 1'b1;
        end else if (accept) begin
            pend_q <= 1'b0;
        end
    end

    // Burst state machine and beat counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            beat    <= '0;
        end else begin
            case (state_q)
                FS_IDLE: if (pend_q) state_q <= FS_ADDR;
                FS_ADDR: if (mem_ack) begin
                    state_q <= FS_DATA;
                    beat    <= '0;
                end
                FS_DATA: if (mem_dvalid) begin
                    beat <= beat + 1'b1;
                    if (last_beat) state_q <= FS_IDLE;
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lfetch_pos.sv
// Position tracker: row and burst counters, page latch and burst address.
// Assumes: accept and burst_done alternate, one pair per burst.
module lfetch_pos #(
    parameter int               ADDR_W      = 24,
    parameter int               BURST_BYTES = 32,
    parameter int               ROW_BYTES   = 416,
    parameter int               FRAME_ROWS  = 262,
    parameter logic [ADDR_W-1:0] PAGE0_BASE = '0,
    parameter logic [ADDR_W-1:0] PAGE1_BASE = '0,
    localparam int BPR    = ROW_BYTES / BURST_BYTES,
    localparam int BIDX_W = $clog2(BPR),
    localparam int ROW_W  = $clog2(FRAME_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              burst_done,
    input  logic              page_sel,
    output logic              row_lsb,
    output logic [BIDX_W-1:0] bidx,
    output logic [ADDR_W-1:0] mem_addr
);
    logic [ROW_W-1:0]  row_q;
    logic [ADDR_W-1:0] row_off_q;
    logic              page_q;
    logic [ADDR_W-1:0] page_base;

    // Latch the page choice when the first burst of a frame is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= 1'b0;
        end else if (accept && row_q == '0 && bidx == '0) begin
            page_q <= page_sel;
        end
    end

    // Step burst index, row and row byte offset after each finished burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bidx      <= '0;
            row_q     <= '0;
            row_off_q <= '0;
        end else if (burst_done) begin
            if (bidx == BIDX_W'(BPR - 1)) begin
                bidx <= '0;
                if (row_q == ROW_W'(FRAME_ROWS - 1)) begin
                    row_q     <= '0;
                    row_off_q <= '0;
                end else begin
                    row_q     <= row_q + 1'b1;
                    row_off_q <= row_off_q + ADDR_W'(ROW_BYTES);
                end
            end else begin
                bidx <= bidx + 1'b1;
            end
        end
    end

    assign page_base = page_q ? PAGE1_BASE : PAGE0_BASE;
    assign row_lsb   = row_q[0];
    assign mem_addr  = page_base + row_off_q + ADDR_W'(bidx) * ADDR_W'(BURST_BYTES);
endmodule

// File: rtl/burst_line_fetcher.sv
// Top of the line fetcher: synchronizes video requests, runs one memory
// burst per request and writes the beats into the two-line cache RAM.
// Assumes: the line RAM is dual-ported, with this side on the bus clock.
module burst_line_fetcher #(
    parameter int               ADDR_W      = 24,
    parameter int               BURST_BYTES = 32,
    parameter int               ROW_BYTES   = 416,
    parameter int               FRAME_ROWS  = 262,
    parameter int               HALF_STRIDE = 512,
    parameter logic [ADDR_W-1:0] PAGE0_BASE = 24'h000000,
    parameter logic [ADDR_W-1:0] PAGE1_BASE = 24'h020000,
    localparam int BEAT_W  = $clog2(BURST_BYTES),
    localparam int BIDX_W  = $clog2(ROW_BYTES / BURST_BYTES),
    localparam int LRAM_AW = $clog2(2 * HALF_STRIDE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vid_req_tgl,
    input  logic               page_sel,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic               mem_ack,
    input  logic               mem_dvalid,
    input  logic [7:0]         mem_rdata,
    output logic               lram_we,
    output logic [LRAM_AW-1:0] lram_waddr,
    output logic [7:0]         lram_wdata
);
    logic              req_pulse;
    logic              accept;
    logic              burst_done;
    logic [BEAT_W-1:0] beat;
    logic              row_lsb;
    logic [BIDX_W-1:0] bidx;

    lfetch_req_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tgl_in    (vid_req_tgl),
        .req_pulse (req_pulse)
    );

    lfetch_seq #(.BURST_BYTES(BURST_BYTES)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_pulse  (req_pulse),
        .mem_ack    (mem_ack),
        .mem_dvalid (mem_dvalid),
        .mem_req    (mem_req),
        .accept     (accept),
        .burst_done (burst_done),
        .beat_we    (lram_we),
        .beat       (beat)
    );

    lfetch_pos #(
        .ADDR_W      (ADDR_W),
        .BURST_BYTES (BURST_BYTES),
        .ROW_BYTES   (ROW_BYTES),
        .FRAME_ROWS  (FRAME_ROWS),
        .PAGE0_BASE  (PAGE0_BASE),
        .PAGE1_BASE  (PAGE1_BASE)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .burst_done (burst_done),
        .page_sel   (page_sel),
        .row_lsb    (row_lsb),
        .bidx       (bidx),
        .mem_addr   (mem_addr)
    );

    // Line RAM write address: row half, burst slot, beat.
    assign lram_waddr = LRAM_AW'(row_lsb) * LRAM_AW'(HALF_STRIDE)
                      + LRAM_AW'(bidx) * LRAM_AW'(BURST_BYTES)
                      + LRAM_AW'(beat);
    assign lram_wdata = mem_rdata;
endmodule

// File: rtl/lfetch_checker.sv
// Protocol checks for the line fetcher, attached to the top by bind.
// Assumes: synchronous active-low reset on the same clock.
module lfetch_checker #(
    parameter int ADDR_W    = 24,
    parameter int LRAM_AW   = 10,
    parameter int ROW_BYTES = 416
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req,
    input logic               mem_ack,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic               mem_dvalid,
    input logic               lram_we,
    input logic [LRAM_AW-1:0] lram_waddr
);
    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_req_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    p_we_needs_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lram_we |-> mem_dvalid);

    p_no_req_in_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lram_we |-> !mem_req);

    p_slot_in_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lram_we |-> (lram_waddr[LRAM_AW-2:0] < (LRAM_AW-1)'(ROW_BYTES)));
endmodule

bind burst_line_fetcher lfetch_checker #(
    .ADDR_W    (ADDR_W),
    .LRAM_AW   (LRAM_AW),
    .ROW_BYTES (ROW_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .mem_dvalid (mem_dvalid),
    .lram_we    (lram_we),
    .lram_waddr (lram_waddr)
);

// File: tb/burst_line_fetcher_tb.sv
// Bench: memory model with a behavioural reference queue of expected writes.
module burst_line_fetcher_tb;
    localparam int          AW    = 24;
    localparam int          ROWS  = 4;
    localparam int          BPR   = 13;
    localparam logic [23:0] BASE0 = 24'h001000;
    localparam logic [23:0] BASE1 = 24'h040000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vid_req_tgl = 1'b0;
    logic        page_sel = 1'b0;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic        mem_dvalid = 1'b0;
    logic [7:0]  mem_rdata = 8'h00;
    logic        lram_we;
    logic [9:0]  lram_waddr;
    logic [7:0]  lram_wdata;

    int checks = 0;
    int errors = 0;
    int bursts_done = 0;
    int writes_seen = 0;
    int stray_req = 0;
    int stray_done = 0;
    int r_row = 0;
    int r_burst = 0;
    logic        r_page = 1'b0;
    logic [23:0] frame_addr = '0;
    int          frames_started = 0;
    logic [17:0] exp_q[$];

    always #2 clk = ~clk;

    burst_line_fetcher #(
        .ADDR_W(AW), .FRAME_ROWS(ROWS), .PAGE0_BASE(BASE0), .PAGE1_BASE(BASE1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .vid_req_tgl(vid_req_tgl), .page_sel(page_sel),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_dvalid(mem_dvalid), .mem_rdata(mem_rdata), .lram_we(lram_we),
        .lram_waddr(lram_waddr), .lram_wdata(lram_wdata)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Memory model: checks burst address, acknowledges, returns 32 beats.
    initial begin
        logic [23:0] ea;
        forever begin
            @(negedge clk);
            if (stray_req != stray_done) begin
                mem_dvalid = 1'b1;
                mem_rdata  = 8'hEE;
                @(negedge clk);
                mem_dvalid = 1'b0;
                stray_done++;
            end else if (mem_req) begin
                if (r_row == 0 && r_burst == 0) r_page = page_sel;
                ea = (r_page ? BASE1 : BASE0) + 24'(r_row * 416 + r_burst * 32);
                if (r_row == 0 && r_burst == 0) begin
                    frame_addr = mem_addr;
                    frames_started++;
                end
                check(mem_addr == ea, "R2 burst address", mem_addr, ea);
                for (int b = 0; b < 32; b++)
                    exp_q.push_back({10'((r_row % 2) * 512 + r_burst * 32 + b), mem_byte(ea + 24'(b))});
                @(negedge clk);
                check(mem_req == 1'b1 && mem_addr == ea, "R10 request held", mem_addr, ea);
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
                check(mem_req == 1'b0, "R1 request drops after ack", mem_req, 0);
                for (int b = 0; b < 32; b++) begin
                    if (b % 5 == 3) @(negedge clk);
                    mem_dvalid = 1'b1;
                    mem_rdata  = mem_byte(ea + 24'(b));
                    @(negedge clk);
                    mem_dvalid = 1'b0;
                end
                r_burst++;
                if (r_burst == BPR) begin
                    r_burst = 0;
                    r_row = (r_row + 1) % ROWS;   // R4 wrap
                end
                bursts_done++;
            end
        end
    end

    // Reference compare of every write, in the middle of the low phase.
    initial begin
        logic [17:0] e;
        forever begin
            @(negedge clk);
            #1;
            if (lram_we) begin
                writes_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected write", lram_waddr, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({lram_waddr, lram_wdata} == e, "R3 write addr/data",
                          {lram_waddr, lram_wdata}, e);
                end
            end
        end
    end

    task automatic one_req(input int gap);
        int target;
        target = bursts_done + 1;
        @(negedge clk);
        vid_req_tgl = ~vid_req_tgl;
        wait (bursts_done >= target);
        repeat (gap) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", bursts_done, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n0, w0, f0;
        repeat (4) @(negedge clk);
        check(mem_req == 1'b0, "R8 reset mem_req", mem_req, 0);
        check(lram_we == 1'b0, "R8 reset lram_we", lram_we, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6: four rising edges from toggle to request.
        vid_req_tgl = ~vid_req_tgl;
        repeat (3) @(posedge clk);
        #1 check(mem_req == 1'b0, "R6 no request before 4th edge", mem_req, 0);
        @(posedge clk);
        #1 check(mem_req == 1'b1, "R6 request after 4th edge", mem_req, 1);
        check(mem_addr == BASE0, "R8 first burst at row 0 slot 0", mem_addr, BASE0);
        wait (bursts_done == 1);

        // R1/R4: varied spacing across rows.
        for (int i = 0; i < 20; i++) one_req(i % 4);

        // R7: second request during a burst is served later.
        n0 = bursts_done;
        @(negedge clk);
        vid_req_tgl = ~vid_req_tgl;
        wait (mem_dvalid == 1'b1);
        @(negedge clk);
        vid_req_tgl = ~vid_req_tgl;
        wait (bursts_done >= n0 + 2);
        repeat (10) @(negedge clk);
        check(bursts_done == n0 + 2, "R7 held request served", bursts_done, n0 + 2);

        // R9: stray data-valid while idle.
        w0 = writes_seen;
        stray_req++;
        wait (stray_done == stray_req);
        repeat (3) @(negedge clk);
        check(writes_seen == w0, "R9 stray beat ignored", writes_seen, w0);
        one_req(2);

        // R5: change page mid-frame; takes effect at next frame start.
        page_sel = 1'b1;
        f0 = frames_started;
        while (frames_started == f0) one_req(1);
        check(frame_addr == BASE1, "R5 new page at frame start", frame_addr, BASE1);
        one_req(1);
        page_sel = 1'b0;
        f0 = frames_started;
        while (frames_started == f0) one_req(0);
        check(frame_addr == BASE0, "R4 wrap to row 0 with page 0", frame_addr, BASE0);
        one_req(3);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R1 all beats written", exp_q.size(), 0);
        check(writes_seen == bursts_done * 32, "R1 32 writes per burst", writes_seen, bursts_done * 32);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule